// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a two-part logical address (a segment number plus an offset into that segment) into a physical address. A small on-chip table holds one descriptor per segment. Each descriptor has a 32-bit start address, a 20-bit segment length and three permission bits. Software fills the table through a write port. A separate count register says how many segments, starting from segment 0, are currently in use.

Every lookup goes through three checks. The first asks whether the segment number is in use. The second asks whether the offset lies inside the segment's length. The third asks whether the access kind is permitted by the descriptor. If all three pass, the unit returns the descriptor's start address plus the offset. If any check fails, it returns a two-bit fault cause and a zero address. Results are registered, so they appear one clock after the request.

Top module: `seg_xlate_unit`

## Requirements
- R1: While reset is asserted and after it is released, out_valid, out_trap and out_paddr are all zero, the count register is zero and every descriptor is cleared.
- R2: When wr_en is high at a rising edge, the descriptor at wr_idx takes wr_base, wr_limit and wr_perm. The permission bits are read = bit 0, write = bit 1 and execute = bit 2.
- R3: When cnt_wr_en is high at a rising edge, the count register takes cnt_val. A segment number s is in use only when s < count; any count above 16 acts like 16. A lookup of a segment that is not in use gives trap code 01.
- R4: A lookup whose offset is greater than or equal to the segment's length gives trap code 10. A segment of length 0 faults for every offset.
- R5: The access kind is coded 00 read, 01 write, 10 execute and 11 treated as read. If the matching permission bit is clear, the lookup gives trap code 11.
- R6: When more than one fault applies, code 01 wins over 10, and 10 wins over 11.
- R7: A lookup with no fault gives trap code 00 and out_paddr = base + zero-extended offset, taken modulo 2^32.
- R8: out_valid equals lk_valid delayed by one clock, and the result belongs to that request. When out_valid is low, out_trap and out_paddr are zero.
- R9: Whenever out_trap is not 00, out_paddr is zero.
- R10: A lookup in the same cycle as a descriptor write or a count write uses the contents from before that write. The next cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | 4 | Descriptor index to write |
| wr_base | input | 32 | Segment start address |
| wr_limit | input | 20 | Segment length |
| wr_perm | input | 3 | Permission bits {execute, write, read} |
| cnt_wr_en | input | 1 | Count register write strobe |
| cnt_val | input | 5 | New segment count |
| lk_valid | input | 1 | Lookup request |
| lk_seg | input | 4 | Segment number |
| lk_off | input | 20 | Offset within the segment |
| lk_acc | input | 2 | Access kind |
| out_valid | output | 1 | Result valid, one clock after the request |
| out_paddr | output | 32 | Physical address, zero on a fault |
| out_trap | output | 2 | Fault cause |

## Verification
Directed lookups put offsets at length minus one and at the length itself, which separates a `<` bound from a `<=` bound. Zero-length segments and descriptors that grant only one permission expose any mix-up in permission bit positions. Crafted requests that hit two or three faults at once pin down the priority order. A start address near the top of the address space shows that the sum wraps. Same-cycle writes to the entry or the count being looked up show whether old or new contents are returned. Random traffic then mixes writes, count changes and lookups with offsets clustered around each segment's length, and compares every result with a model kept in the bench.

// File: rtl/segxlt_pkg.sv
package segxlt_pkg;
    parameter int SEG_NUM = 16;
    parameter int ADDR_W  = 32;
    parameter int LIM_W   = 20;
    parameter int PERM_W  = 3;
    localparam int SEG_W  = $clog2(SEG_NUM);
    localparam int CNT_W  = $clog2(SEG_NUM + 1);

    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic [PERM_W-1:0] perm;
    } seg_entry_t;

    typedef enum logic [1:0] {
        TRAP_NONE  = 2'b00,
        TRAP_SEG   = 2'b01,
        TRAP_LIMIT = 2'b10,
        TRAP_PROT  = 2'b11
    } trap_e;

    typedef enum logic [1:0] {
        ACC_RD  = 2'b00,
        ACC_WR  = 2'b01,
        ACC_EX  = 2'b10,
        ACC_RSV = 2'b11
    } acc_e;
endpackage

// File: rtl/seg_table.sv
module seg_table
    import segxlt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  seg_entry_t       wr_entry,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [SEG_W-1:0] rd_idx,
    output seg_entry_t       rd_entry,
    output logic [CNT_W-1:0] seg_count
);
    typedef struct packed {
        seg_entry_t [SEG_NUM-1:0] ent;
        logic [CNT_W-1:0]         cnt;
    } tbl_state_t;

    tbl_state_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en)
            tbl_d.ent[wr_idx] = wr_entry;
        if (cnt_wr_en)
            tbl_d.cnt = cnt_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tbl_q <= '0;
        else
            tbl_q <= tbl_d;
    end

    // Reads come from the stored state, so a same-cycle write is not seen yet.
    assign rd_entry  = tbl_q.ent[rd_idx];
    assign seg_count = tbl_q.cnt;

    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en |=> seg_count == $past(cnt_val));

    // R2
    ent_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_idx == wr_idx) |=> ($past(rd_idx) != rd_idx) || rd_entry == $past(wr_entry));
endmodule

// File: rtl/seg_check.sv
module seg_check
    import segxlt_pkg::*;
(
    input  seg_entry_t        entry,
    input  logic [SEG_W-1:0]  seg,
    input  logic [CNT_W-1:0]  count,
    input  logic [LIM_W-1:0]  off,
    input  acc_e              acc,
    output trap_e             trap,
    output logic [ADDR_W-1:0] paddr
);
    logic seg_ok;
    logic lim_ok;
    logic perm_ok;

    always_comb begin
        seg_ok = CNT_W'(seg) < count;
        lim_ok = off < entry.limit;
        unique case (acc)
            ACC_WR:  perm_ok = entry.perm[PERM_WR];
            ACC_EX:  perm_ok = entry.perm[PERM_EX];
            default: perm_ok = entry.perm[PERM_RD];
        endcase

        if (!seg_ok)
            trap = TRAP_SEG;
        else if (!lim_ok)
            trap = TRAP_LIMIT;
        else if (!perm_ok)
            trap = TRAP_PROT;
        else
            trap = TRAP_NONE;

        paddr = entry.base + ADDR_W'(off);
    end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import segxlt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_idx,
    input  logic [31:0] wr_base,
    input  logic [19:0] wr_limit,
    input  logic [2:0]  wr_perm,
    input  logic        cnt_wr_en,
    input  logic [4:0]  cnt_val,
    input  logic        lk_valid,
    input  logic [3:0]  lk_seg,
    input  logic [19:0] lk_off,
    input  logic [1:0]  lk_acc,
    output logic        out_valid,
    output logic [31:0] out_paddr,
    output logic [1:0]  out_trap
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] paddr;
        trap_e             trap;
    } res_state_t;

    res_state_t res_d, res_q;

    seg_entry_t        wr_entry;
    seg_entry_t        rd_entry;
    logic [CNT_W-1:0]  seg_count;
    trap_e             chk_trap;
    logic [ADDR_W-1:0] chk_paddr;

    assign wr_entry = '{base: wr_base, limit: wr_limit, perm: wr_perm};

    seg_table u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_entry  (wr_entry),
        .cnt_wr_en (cnt_wr_en),
        .cnt_val   (cnt_val),
        .rd_idx    (lk_seg),
        .rd_entry  (rd_entry),
        .seg_count (seg_count)
    );

    seg_check u_check (
        .entry (rd_entry),
        .seg   (lk_seg),
        .count (seg_count),
        .off   (lk_off),
        .acc   (acc_e'(lk_acc)),
        .trap  (chk_trap),
        .paddr (chk_paddr)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = lk_valid;
        res_d.trap  = TRAP_NONE;
        if (lk_valid) begin
            res_d.trap = chk_trap;
            if (chk_trap == TRAP_NONE)
                res_d.paddr = chk_paddr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_paddr = res_q.paddr;
    assign out_trap  = res_q.trap;

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> out_valid);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!out_valid && out_trap == 2'b00 && out_paddr == '0));

    // R9
    trap_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap != 2'b00 |-> out_paddr == '0);

    // R6
    illegal_seg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && CNT_W'(lk_seg) >= seg_count) |=> out_trap == 2'b01);
endmodule

// File: tb/seg_xlate_unit_bench.sv
`timescale 1ns/1ps
module seg_xlate_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_base = '0;
    logic [19:0] wr_limit = '0;
    logic [2:0]  wr_perm = '0;
    logic        cnt_wr_en = 1'b0;
    logic [4:0]  cnt_val = '0;
    logic        lk_valid = 1'b0;
    logic [3:0]  lk_seg = '0;
    logic [19:0] lk_off = '0;
    logic [1:0]  lk_acc = '0;
    logic        out_valid;
    logic [31:0] out_paddr;
    logic [1:0]  out_trap;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_base [16];
    logic [19:0] m_lim  [16];
    logic [2:0]  m_perm [16];
    logic [4:0]  m_cnt;

    always #2 clk = ~clk;

    seg_xlate_unit u_seg_xlate_unit (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base), .wr_limit(wr_limit), .wr_perm(wr_perm),
        .cnt_wr_en(cnt_wr_en), .cnt_val(cnt_val),
        .lk_valid(lk_valid), .lk_seg(lk_seg), .lk_off(lk_off), .lk_acc(lk_acc),
        .out_valid(out_valid), .out_paddr(out_paddr), .out_trap(out_trap)
    );

    function automatic logic [1:0] exp_trap(input logic [3:0] s, input logic [19:0] o, input logic [1:0] a);
        logic ok;
        if ({1'b0, s} >= m_cnt) return 2'b01;
        if (o >= m_lim[s]) return 2'b10;
        case (a)
            2'b01:   ok = m_perm[s][1];
            2'b10:   ok = m_perm[s][2];
            default: ok = m_perm[s][0];
        endcase
        return ok ? 2'b00 : 2'b11;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [3:0] s, input logic [19:0] o, input logic [1:0] t);
        if (t != 2'b00) return 32'h0;
        return m_base[s] + {12'h0, o};
    endfunction

    function automatic string tag_of(input logic [1:0] t);
        case (t)
            2'b00:   return "R7";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic v, input logic [1:0] t, input logic [31:0] a);
        n_chk++;
        if (out_valid !== v || out_trap !== t || out_paddr !== a) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b trap=%b paddr=%h, expected valid=%0b trap=%b paddr=%h",
                     tag, out_valid, out_trap, out_paddr, v, t, a);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] s, input logic [19:0] o, input logic [1:0] a,
                        input logic we, input logic [3:0] wi, input logic [31:0] wb,
                        input logic [19:0] wl, input logic [2:0] wp,
                        input logic ce, input logic [4:0] cv, input string tag);
        logic [1:0]  et;
        logic [31:0] ea;
        string       tg;
        lk_valid = v; lk_seg = s; lk_off = o; lk_acc = a;
        wr_en = we; wr_idx = wi; wr_base = wb; wr_limit = wl; wr_perm = wp;
        cnt_wr_en = ce; cnt_val = cv;
        et = v ? exp_trap(s, o, a) : 2'b00;
        ea = v ? exp_addr(s, o, et) : 32'h0;
        tg = (tag == "") ? tag_of(et) : tag;
        if (we) begin m_base[wi] = wb; m_lim[wi] = wl; m_perm[wi] = wp; end
        if (ce) m_cnt = cv;
        @(negedge clk);
        check(tg, v, et, ea);
    endtask

    task automatic look(input logic [3:0] s, input logic [19:0] o, input logic [1:0] a, input string tag);
        step(1'b1, s, o, a, 1'b0, 4'h0, 32'h0, 20'h0, 3'h0, 1'b0, 5'h0, tag);
    endtask

    task automatic put(input logic [3:0] wi, input logic [31:0] wb, input logic [19:0] wl, input logic [2:0] wp);
        step(1'b0, 4'h0, 20'h0, 2'b00, 1'b1, wi, wb, wl, wp, 1'b0, 5'h0, "R2");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got no end of run, expected end within 200000 cycles");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin m_base[i] = '0; m_lim[i] = '0; m_perm[i] = '0; end
        m_cnt = '0;
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 2'b00, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0, 2'b00, 32'h0);
        // R1: count is zero after reset, so segment 0 is not in use
        look(4'd0, 20'h0, 2'b00, "R1");

        put(4'd0, 32'h1000_0000, 20'h00100, 3'b111);
        put(4'd1, 32'hFFFF_FF00, 20'h00200, 3'b001);
        put(4'd2, 32'h0000_8000, 20'h00000, 3'b111);
        put(4'd15, 32'h0000_0040, 20'hFFFFF, 3'b100);
        // R10: count write in the same cycle as a lookup, old count 0 applies
        step(1'b1, 4'd0, 20'h0, 2'b00, 1'b0, 4'h0, 32'h0, 20'h0, 3'h0, 1'b1, 5'd3, "R10");
        look(4'd0, 20'h000FF, 2'b00, "R7");
        look(4'd0, 20'h00100, 2'b00, "R4");
        look(4'd1, 20'h00010, 2'b01, "R5");
        look(4'd1, 20'h00150, 2'b00, "R7");
        look(4'd1, 20'h00010, 2'b11, "R5");
        look(4'd1, 20'h00300, 2'b01, "R6");
        look(4'd2, 20'h00000, 2'b00, "R4");
        look(4'd15, 20'hFFFFF, 2'b01, "R6");
        step(1'b0, 4'h0, 20'h0, 2'b00, 1'b0, 4'h0, 32'h0, 20'h0, 3'h0, 1'b1, 5'd16, "R8");
        look(4'd15, 20'hFFFFE, 2'b10, "R7");
        look(4'd15, 20'h00001, 2'b00, "R5");
        step(1'b0, 4'h0, 20'h0, 2'b00, 1'b0, 4'h0, 32'h0, 20'h0, 3'h0, 1'b1, 5'd20, "R8");
        look(4'd15, 20'h00002, 2'b10, "R3");
        // R10: write to segment 0 in the same cycle as its lookup returns old base
        step(1'b1, 4'd0, 20'h00004, 2'b00, 1'b1, 4'd0, 32'h2000_0000, 20'h00010, 3'b001, 1'b0, 5'h0, "R10");
        look(4'd0, 20'h00004, 2'b00, "R10");
        look(4'd0, 20'h00010, 2'b00, "R4");

        for (int k = 0; k < 4000; k++) begin
            logic [3:0]  s;
            logic [19:0] o;
            logic [19:0] wl;
            logic [3:0]  wi;
            s  = 4'($urandom_range(0, 15));
            wi = ($urandom_range(0, 3) == 0) ? s : 4'($urandom_range(0, 15));
            wl = ($urandom_range(0, 1) == 0) ? 20'($urandom_range(0, 64)) : 20'($urandom);
            case ($urandom_range(0, 3))
                0:       o = m_lim[s] - 20'd1;
                1:       o = m_lim[s];
                2:       o = 20'($urandom_range(0, 80));
                default: o = 20'($urandom);
            endcase
            step($urandom_range(0, 3) != 0, s, o, 2'($urandom_range(0, 3)),
                 $urandom_range(0, 3) == 0, wi, $urandom, wl, 3'($urandom_range(0, 7)),
                 $urandom_range(0, 15) == 0, 5'($urandom_range(0, 20)), "");
        end
        finish_run();
    end
endmodule